// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block is the four-entry, byte-wide holding queue that sits between a serial deserializer and the register interface of a receiver. The deserializer offers received bytes and break events. The register side pops bytes in arrival order. The block reports whether any byte is waiting and whether the queue is full. It also tells the deserializer when a normal byte may be offered.

A break event raises a sticky break-change flag and always enters a zero byte. If the queue already holds four bytes, the zero takes the place of the newest byte rather than being lost. A pop of an empty queue returns zero and changes nothing. A flush input, driven by the receiver-reset command, empties the queue.

Control is a fill-level state machine with three states:
- `ST_EMPTY` holds no bytes.
- `ST_PARTIAL` holds one to three bytes.
- `ST_FULL` holds four bytes.

Its transitions are:
- *fill-start*: `ST_EMPTY` to `ST_PARTIAL`, on a push without a pop.
- *fill-top*: `ST_PARTIAL` to `ST_FULL`, on a push without a pop while three bytes are held.
- *drain-last*: `ST_PARTIAL` to `ST_EMPTY`, on a pop without a push while one byte is held.
- *drain-top*: `ST_FULL` to `ST_PARTIAL`, on a pop without a push.
- *flush*: any state to `ST_EMPTY`.

The two pointers and the byte count sit beside the state register.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the queue is empty: `rx_ready_o`=0, `full_o`=0, `brk_flag_o`=0, `pop_data_o`=0x00.
- R2: Bytes leave in the order they entered. `full_o` is 1 exactly when four bytes are held.
- R3: `rx_ready_o` is 1 whenever at least one byte is held. It goes to 0 only when a pop or a flush empties the queue.
- R4: `accept_o` equals `rx_en_i` AND NOT `full_o`. A normal byte (`push_valid_i`=1) is stored only when `accept_o`=1 and `brk_i`=0. Otherwise it is ignored.
- R5: A break (`brk_i`=1) stores the byte 0x00 and sets `brk_flag_o` on the next cycle, whether or not `rx_en_i` is set. A normal byte offered in the same cycle is discarded.
- R6: A break arriving while four bytes are held, with no pop in the same cycle, replaces the newest byte with 0x00. The count stays at four and the older three bytes are kept.
- R7: When the queue is empty, `pop_data_o` is 0x00, and a pop changes no state.
- R8: `flush_i`=1 empties the queue and clears `rx_ready_o` and `full_o` on the next cycle. It takes priority over any push or pop in the same cycle.
- R9: A push and a pop in the same cycle on a non-empty queue leave the count unchanged and keep arrival order.
- R10: `brk_clr_i`=1 clears `brk_flag_o` unless a break arrives in the same cycle. A flush does not touch the flag.
- R11: A pop from a full queue clears `full_o` unless a push lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enabled |
| push_valid_i | input | 1 | Normal received byte offered |
| push_data_i | input | 8 | Received byte |
| brk_i | input | 1 | Break event, one cycle per event |
| pop_i | input | 1 | Register side takes the head byte |
| flush_i | input | 1 | Receiver reset: empty the queue |
| brk_clr_i | input | 1 | Clear the break-change flag |
| pop_data_o | output | 8 | Head byte, 0x00 when empty |
| rx_ready_o | output | 1 | At least one byte held |
| full_o | output | 1 | Four bytes held |
| accept_o | output | 1 | Deserializer may offer a normal byte |
| brk_flag_o | output | 1 | Sticky break-change flag |

## Verification
The bench builds the block with its default parameters: 8-bit data and depth four. At depth four, a few pushes reach the full state, where ignored bytes, break overwrites and the combined push-pop in the full state can all be exercised. Random traffic with a low break rate and occasional flushes repeatedly drives the count from empty to full and back. A queue model in the bench predicts every flag and popped byte, including break and flush collisions.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (wr_en && (wr_addr == PTR_W'(i))) begin
                slot_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en_i,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              brk_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic              brk_clr_i,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic              rx_ready_o,
    output logic              full_o,
    output logic              accept_o,
    output logic              brk_flag_o
);
    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
    logic             brk_q;
    logic             is_full, is_empty, byte_ok, push, pop, overwrite, grow, shrink;

    // Datapath decisions
    always_comb begin
        is_full   = (state_q == ST_FULL);
        is_empty  = (state_q == ST_EMPTY);
        byte_ok   = push_valid_i & rx_en_i & ~is_full & ~brk_i;
        push      = (brk_i | byte_ok) & ~flush_i;
        pop       = pop_i & ~is_empty & ~flush_i;
        overwrite = push & is_full & ~pop;
        grow      = push & ~overwrite & ~pop;
        shrink    = pop & ~push;
        wr_en_o   = push;
        wr_addr_o = overwrite ? (wr_q - PTR_W'(1)) : wr_q;
        wr_data_o = brk_i ? '0 : push_data_i;
        rd_addr_o = rd_q;
        if (flush_i) begin
            cnt_d = '0;
            wr_d  = '0;
            rd_d  = '0;
        end else begin
            cnt_d = grow ? cnt_q + CNT_W'(1) : (shrink ? cnt_q - CNT_W'(1) : cnt_q);
            wr_d  = (push && !overwrite) ? wr_q + PTR_W'(1) : wr_q;
            rd_d  = pop ? rd_q + PTR_W'(1) : rd_q;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (grow) state_d = ST_PARTIAL;                         // fill-start
            end
            ST_PARTIAL: begin
                if (grow && cnt_q == CNT_W'(DEPTH - 1)) state_d = ST_FULL; // fill-top
                else if (shrink && cnt_q == CNT_W'(1)) state_d = ST_EMPTY; // drain-last
            end
            ST_FULL: begin
                if (shrink) state_d = ST_PARTIAL;                       // drain-top
            end
            default: state_d = ST_EMPTY;
        endcase
        if (flush_i) state_d = ST_EMPTY;                                // flush
    end

    // State register, pointers and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
            rd_q    <= rd_d;
            if (brk_i) brk_q <= 1'b1;
            else if (brk_clr_i) brk_q <= 1'b0;
        end
    end

    // Outputs from state
    always_comb begin
        rx_ready_o = (state_q != ST_EMPTY);
        full_o     = (state_q == ST_FULL);
        accept_o   = rx_en_i & (state_q != ST_FULL);
        brk_flag_o = brk_q;
    end
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en_i,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              brk_i,
    input  logic              pop_i,
    input  logic              flush_i,
    input  logic              brk_clr_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              rx_ready_o,
    output logic              full_o,
    output logic              accept_o,
    output logic              brk_flag_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    rxq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .push_valid_i(push_valid_i),
        .push_data_i(push_data_i), .brk_i(brk_i), .pop_i(pop_i), .flush_i(flush_i),
        .brk_clr_i(brk_clr_i), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rx_ready_o(rx_ready_o), .full_o(full_o),
        .accept_o(accept_o), .brk_flag_o(brk_flag_o)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign pop_data_o = rx_ready_o ? rd_data : '0;
endmodule

// File: rtl/rxq_buffer_chk.sv
module rxq_buffer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en_i,
    input logic              push_valid_i,
    input logic              brk_i,
    input logic              pop_i,
    input logic              flush_i,
    input logic              brk_clr_i,
    input logic [DATA_W-1:0] pop_data_o,
    input logic              rx_ready_o,
    input logic              full_o,
    input logic              accept_o,
    input logic              brk_flag_o
);
    a_r2_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> rx_ready_o);
    a_r4_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !accept_o);
    a_r5_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> brk_flag_o);
    a_r5_break_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !flush_i) |=> rx_ready_o);
    a_r6_break_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && brk_i && !pop_i && !flush_i) |=> full_o);
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready_o |-> (pop_data_o == '0));
    a_r7_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready_o && !brk_i && !(push_valid_i && rx_en_i)) |=> !rx_ready_o);
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!rx_ready_o && !full_o));
    a_r10_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr_i && !brk_i) |=> !brk_flag_o);
    a_r11_pop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && pop_i && !brk_i && !flush_i) |=> !full_o);
endmodule

bind rxq_buffer rxq_buffer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .push_valid_i(push_valid_i),
    .brk_i(brk_i), .pop_i(pop_i), .flush_i(flush_i), .brk_clr_i(brk_clr_i),
    .pop_data_o(pop_data_o), .rx_ready_o(rx_ready_o), .full_o(full_o),
    .accept_o(accept_o), .brk_flag_o(brk_flag_o)
);

// File: tb/tb_rxq_buffer.sv
module tb_rxq_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en_i = 1'b0, push_valid_i = 1'b0, brk_i = 1'b0;
    logic       pop_i = 1'b0, flush_i = 1'b0, brk_clr_i = 1'b0;
    logic [7:0] push_data_i = 8'h00;
    logic [7:0] pop_data_o;
    logic       rx_ready_o, full_o, accept_o, brk_flag_o;

    int checks = 0, fails = 0, cycles = 0;
    logic [7:0] mq [DEPTH];
    int  mcnt = 0;
    bit  mflag = 0;

    rxq_buffer dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_head();
        return (mcnt == 0) ? 8'h00 : mq[0];
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: inputs driven at the falling edge, pre-edge outputs checked, model stepped.
    task automatic step(bit en, bit v, logic [7:0] d, bit b, bit p, bit f, bit c);
        bit push;
        rx_en_i = en; push_valid_i = v; push_data_i = d; brk_i = b;
        pop_i = p; flush_i = f; brk_clr_i = c;
        #1;
        chk("R2 full", full_o, mcnt == DEPTH);
        chk("R3 ready", rx_ready_o, mcnt != 0);
        chk("R4 accept", accept_o, en && mcnt < DEPTH);
        chk("R10 flag", brk_flag_o, mflag);
        chk("R2/R7 head", pop_data_o, exp_head());
        if (f) mcnt = 0;
        else begin
            push = b || (v && en && mcnt < DEPTH);
            if (p && mcnt > 0) begin
                for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (push) begin
                if (mcnt == DEPTH) mq[DEPTH-1] = b ? 8'h00 : d;
                else begin mq[mcnt] = b ? 8'h00 : d; mcnt++; end
            end
        end
        if (b) mflag = 1;
        else if (c) mflag = 0;
        @(negedge clk);
    endtask

    task automatic idle(); step(1, 0, 0, 0, 0, 0, 0); endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0417));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", rx_ready_o, 0);
        chk("R1 full", full_o, 0);
        chk("R1 flag", brk_flag_o, 0);
        chk("R1 data", pop_data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 pop of empty
        step(1, 0, 0, 0, 1, 0, 0);
        idle();
        // R2 fill to four, R4 fifth byte ignored
        for (int i = 0; i < 5; i++) step(1, 1, 8'hA0 + 8'(i), 0, 0, 0, 0);
        idle();
        // R6 break while full replaces newest
        step(1, 0, 0, 1, 0, 0, 0);
        idle();
        // R11 pop from full, R2 order drains, R3 clears at empty
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1, 0, 0);
        idle();
        // R4 disabled receiver ignores byte; R5 break still stored
        step(0, 1, 8'h33, 0, 0, 0, 0);
        step(0, 1, 8'h44, 1, 0, 0, 0);
        idle();
        // R10 clear flag, and break wins over clear
        step(1, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 1);
        // R9 simultaneous push and pop
        step(1, 1, 8'h55, 0, 1, 0, 0);
        step(1, 1, 8'h66, 0, 1, 0, 0);
        // R8 flush with push and pop
        step(1, 1, 8'h77, 0, 1, 1, 0);
        idle();
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 8) != 0, ($urandom % 2) == 1, 8'($urandom),
                 ($urandom % 16) == 0, ($urandom % 3) == 0,
                 ($urandom % 64) == 0, ($urandom % 8) == 0);
        end
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule